// File: doc/BRIEF.md
# Serial ADC Acquisition Controller

This block sits on the host side of a three-wire link to a single-channel 8-bit serial converter. A start request begins one acquisition. The controller holds the convert-strobe pin high for a fixed autozero interval and then drops it. It keeps the strobe low while it waits out the worst-case conversion time. It then reads the result through eight clock pulses. The serial clock idles low, as in SPI mode 0, and runs at a divided rate. The converter puts its most significant bit on the data line as soon as the conversion ends, so the controller takes that bit before it issues the first clock pulse. It takes each later bit on a rising clock edge.

All timing is given in system-clock cycles through parameters. The parameters are checked against the converter's minimum times, using the system clock rate in MHz. After the eighth pulse the controller waits a programmable gap. It then posts the sample with a one-cycle valid strobe, and busy drops in that same cycle. The length of the gap sets the maximum sample rate. A start request that arrives while the controller is busy is ignored.

Top module: `adc_acq_ctrl`

## Requirements
- R1: After reset, `busy_o`, `valid_o`, `convst_o` and `sclk_o` are all low, and the controller waits for `start_i`.
- R2: A start accepted while idle drives `convst_o` high from the next cycle for exactly `AZ_CYC` cycles, then drives it low.
- R3: The most significant bit is sampled `CONV_CYC` cycles after `convst_o` falls, before any clock pulse. The first rising edge of `sclk_o` follows `CONV_CYC + HALF_CYC` cycles after the fall.
- R4: `sclk_o` idles low and gives exactly eight pulses per sample. Each high phase lasts `HALF_CYC` cycles, and so does each low phase between pulses.
- R5: `convst_o` stays low from its fall until the sample is posted, and `sclk_o` is never high while `convst_o` is high.
- R6: `data_o` is the received byte in straight binary. Bit 7 is the bit taken before the first pulse. Bits 6 down to 0 are taken on the rising edges of pulses 2 through 8, in that order.
- R7: `valid_o` is high for exactly one cycle per sample. `busy_o` drops in that same cycle, and `data_o` holds its value until the next strobe.
- R8: `busy_o` stays high for exactly `AZ_CYC + CONV_CYC + 16*HALF_CYC + GAP_CYC` cycles per sample.
- R9: `start_i` is ignored while `busy_o` is high, including during the post-read gap. No extra strobe pulse and no extra result are produced.
- R10: The timing parameters meet the converter limits at `CLK_MHZ`: autozero of at least 1 µs, a conversion wait of at least 35 µs, an SCLK phase of at least 0.25 µs (2 MHz maximum), and a gap of at least one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Acquisition request, taken when idle |
| busy_o | output | 1 | Acquisition in progress |
| data_o | output | 8 | Last received sample |
| valid_o | output | 1 | One-cycle strobe for a new sample |
| convst_o | output | 1 | Convert strobe to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| dout_i | input | 1 | Serial data from the converter |

## Verification
The converter model returns bytes with alternating bits, all-zero and all-one bytes, and single-bit bytes at each end. These patterns show whether the capture order is reversed, whether a bit is lost or duplicated, and whether the bit taken before the first pulse lands in position 7. The model drives its most significant bit only once the full conversion time has passed, and it corrupts the returned byte if the autozero or clock phases are too short. A shortened wait or a too-fast clock therefore shows up as a data mismatch. Start requests are also raised during the autozero, conversion, readout and gap phases, to show that none of them restarts the sequence.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AZERO,
    ST_CONV,
    ST_READ,
    ST_GAP
  } acq_state_e;

  localparam int SAMPLE_W = 8;

endpackage

// File: rtl/adc_acq_cnt.sv
module adc_acq_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = val_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_acq_sclk.sv
module adc_acq_sclk #(
  parameter int HALF_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o,
  output logic first_o,
  output logic last_fall_o
);

  localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [PW-1:0] ph_q, ph_d;
  logic          lvl_q, lvl_d;
  logic [2:0]    npl_q, npl_d;
  logic          half_end;

  assign half_end    = (ph_q == PW'(HALF_CYC - 1));
  assign rise_o      = en_i & ~lvl_q & half_end;
  assign first_o     = (npl_q == 3'd0);
  assign last_fall_o = en_i & lvl_q & half_end & (npl_q == 3'd7);
  assign sclk_o      = lvl_q;

  always_comb begin
    ph_d  = ph_q;
    lvl_d = lvl_q;
    npl_d = npl_q;
    if (!en_i) begin
      ph_d  = '0;
      lvl_d = 1'b0;
      npl_d = '0;
    end else if (half_end) begin
      ph_d  = '0;
      lvl_d = ~lvl_q;
      if (lvl_q) npl_d = npl_q + 3'd1;
    end else begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      lvl_q <= 1'b0;
      npl_q <= '0;
    end else begin
      ph_q  <= ph_d;
      lvl_q <= lvl_d;
      npl_q <= npl_d;
    end
  end

endmodule

// File: rtl/adc_acq_shreg.sv
module adc_acq_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);

  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_i) sh_d = {sh_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign word_o = sh_q;

endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl
  import adc_acq_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int AZ_CYC   = 100,
  parameter int CONV_CYC = 3500,
  parameter int HALF_CYC = 25,
  parameter int GAP_CYC  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  output logic                busy_o,
  output logic [SAMPLE_W-1:0] data_o,
  output logic                valid_o,
  output logic                convst_o,
  output logic                sclk_o,
  input  logic                dout_i
);

  localparam int CMAX_AC = (AZ_CYC > CONV_CYC) ? AZ_CYC : CONV_CYC;
  localparam int CMAX    = (CMAX_AC > GAP_CYC) ? CMAX_AC : GAP_CYC;
  localparam int CW      = $clog2(CMAX + 1);

  acq_state_e          state_q, state_d;
  logic                ld;
  logic [CW-1:0]       ld_val;
  logic                cnt_zero;
  logic                rd_en, rise, first, last_fall;
  logic                msb_take, shift;
  logic                fin;
  logic [SAMPLE_W-1:0] word;
  logic [SAMPLE_W-1:0] res_q, res_d;
  logic                valid_q;

  adc_acq_cnt #(.W(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (ld),
    .val_i  (ld_val),
    .zero_o (cnt_zero)
  );

  adc_acq_sclk #(.HALF_CYC(HALF_CYC)) u_sclk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (rd_en),
    .sclk_o      (sclk_o),
    .rise_o      (rise),
    .first_o     (first),
    .last_fall_o (last_fall)
  );

  adc_acq_shreg #(.W(SAMPLE_W)) u_sh (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (shift),
    .bit_i   (dout_i),
    .word_o  (word)
  );

  assign rd_en = (state_q == ST_READ);
  // MSB is taken at the end of the wait; later bits on rising edges 2..8
  assign shift = msb_take | (rise & ~first);

  always_comb begin
    state_d  = state_q;
    ld       = 1'b0;
    ld_val   = '0;
    msb_take = 1'b0;
    fin      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_AZERO;
        ld      = 1'b1;
        ld_val  = CW'(AZ_CYC - 1);
      end
      ST_AZERO: if (cnt_zero) begin
        state_d = ST_CONV;
        ld      = 1'b1;
        ld_val  = CW'(CONV_CYC - 1);
      end
      ST_CONV: if (cnt_zero) begin
        state_d  = ST_READ;
        msb_take = 1'b1;
      end
      ST_READ: if (last_fall) begin
        state_d = ST_GAP;
        ld      = 1'b1;
        ld_val  = CW'(GAP_CYC - 1);
      end
      ST_GAP: if (cnt_zero) begin
        state_d = ST_IDLE;
        fin     = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    res_d = res_q;
    if (fin) res_d = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      valid_q <= fin;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign convst_o = (state_q == ST_AZERO);
  assign data_o   = res_q;
  assign valid_o  = valid_q;

endmodule

// File: rtl/adc_acq_ctrl_chk.sv
module adc_acq_ctrl_chk #(
  parameter int CLK_MHZ  = 100,
  parameter int AZ_CYC   = 100,
  parameter int CONV_CYC = 3500,
  parameter int HALF_CYC = 25,
  parameter int GAP_CYC  = 16
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic valid_o,
  input logic convst_o,
  input logic sclk_o
);

  logic [31:0] hi_cnt;
  logic [3:0]  rise_cnt;
  logic        sclk_q, cv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      rise_cnt <= '0;
      sclk_q   <= 1'b0;
      cv_q     <= 1'b0;
    end else begin
      sclk_q <= sclk_o;
      cv_q   <= convst_o;
      hi_cnt <= convst_o ? hi_cnt + 32'd1 : 32'd0;
      if (convst_o && !cv_q)
        rise_cnt <= '0;
      else if (sclk_o && !sclk_q)
        rise_cnt <= rise_cnt + 4'd1;
    end
  end

  // R10
  initial begin
    az_min_chk: assert (AZ_CYC >= CLK_MHZ)
      else $error("autozero shorter than 1 us");
    conv_min_chk: assert (CONV_CYC >= 35 * CLK_MHZ)
      else $error("conversion wait shorter than 35 us");
    sclk_min_chk: assert (4 * HALF_CYC >= CLK_MHZ)
      else $error("serial clock above 2 MHz");
    gap_min_chk: assert (GAP_CYC >= 1)
      else $error("gap must be at least one cycle");
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R7
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (!busy_o && $past(busy_o)));

  // R9
  convst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convst_o) |-> ($past(start_i) && !$past(busy_o)));

  // R5
  sclk_convst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !convst_o);

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sclk_o);

  // R2
  az_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_o) |-> (hi_cnt == AZ_CYC));

  // R4
  pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (rise_cnt == 4'd8));

endmodule

bind adc_acq_ctrl adc_acq_ctrl_chk #(
  .CLK_MHZ  (CLK_MHZ),
  .AZ_CYC   (AZ_CYC),
  .CONV_CYC (CONV_CYC),
  .HALF_CYC (HALF_CYC),
  .GAP_CYC  (GAP_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .valid_o  (valid_o),
  .convst_o (convst_o),
  .sclk_o   (sclk_o)
);

// File: tb/adc_acq_ctrl_tb.sv
module adc_acq_ctrl_tb;

  localparam int CLK_MHZ  = 100;
  localparam int AZ_CYC   = 100;
  localparam int CONV_CYC = 3500;
  localparam int HALF_CYC = 25;
  localparam int GAP_CYC  = 16;
  localparam int TOTAL    = AZ_CYC + CONV_CYC + 16 * HALF_CYC + GAP_CYC;
  localparam int T_CONV   = 35 * CLK_MHZ;

  logic       clk, rst_n, start, dout;
  logic       busy, valid, convst, sclk;
  logic [7:0] data;

  adc_acq_ctrl #(
    .CLK_MHZ(CLK_MHZ), .AZ_CYC(AZ_CYC), .CONV_CYC(CONV_CYC),
    .HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy),
    .data_o(data), .valid_o(valid), .convst_o(convst), .sclk_o(sclk),
    .dout_i(dout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [7:0] exp_q[$];
  logic [7:0] adc_code;
  int n_req = 0, n_valid = 0, cv_rises = 0;

  // converter model: acts on falling system-clock edges
  logic       m_cv_prev = 0, m_sk_prev = 0, m_active = 0, m_bad = 0;
  logic [7:0] m_word = 0;
  int         m_hi = 0, m_timer = 0, m_bit = 0, m_phase = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      dout = 1'b0;
      m_active = 0;
    end else begin
      if (convst) m_hi++;
      if (m_cv_prev && !convst) begin
        m_word   = adc_code;
        m_bad    = (m_hi < CLK_MHZ);
        m_hi     = 0;
        m_timer  = 1;
        m_bit    = 0;
        m_active = 1;
        dout     = 1'b0;
      end else if (m_active && !convst) begin
        m_timer++;
      end
      if (m_active && m_timer == T_CONV && m_bit == 0)
        dout = m_word[7] ^ m_bad;
      if (sclk != m_sk_prev) begin
        if (4 * m_phase < CLK_MHZ || m_timer < T_CONV) m_bad = 1;
        m_phase = 1;
        if (!sclk && m_active) begin
          m_bit++;
          if (m_bit < 8) dout = m_word[7 - m_bit] ^ m_bad;
          else begin
            dout = 1'b0;
            m_active = 0;
          end
        end
      end else begin
        m_phase++;
      end
      m_cv_prev = convst;
      m_sk_prev = sclk;
    end
  end

  // monitor and scoreboard
  logic cv_prev = 0, sk_prev = 0, vl_prev = 0;
  int   az_run = 0, t_fall = 0, run = 0, rises = 0, bspan = 0;
  bit   waiting = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (convst) begin
        az_run++;
        if (!cv_prev) cv_rises++;
      end else if (cv_prev) begin
        check(az_run == AZ_CYC, "R2 autozero width", az_run, AZ_CYC);
        check(az_run >= CLK_MHZ, "R10 autozero minimum", az_run, CLK_MHZ);
        az_run = 0;
      end
      if (cv_prev && !convst) begin
        t_fall  = 1;
        waiting = 1;
      end else if (waiting) begin
        t_fall++;
      end
      if (sclk != sk_prev) begin
        if (sk_prev)
          check(run == HALF_CYC, "R4 high phase", run, HALF_CYC);
        else if (rises > 0)
          check(run == HALF_CYC, "R4 low phase", run, HALF_CYC);
        if (sk_prev)
          check(4 * run >= CLK_MHZ, "R10 sclk phase minimum", 4 * run, CLK_MHZ);
        run = 1;
      end else begin
        run++;
      end
      if (sclk && !sk_prev) begin
        if (waiting) begin
          check(t_fall == CONV_CYC + HALF_CYC + 1, "R3 first rise", t_fall,
                CONV_CYC + HALF_CYC + 1);
          check(t_fall - HALF_CYC - 1 >= T_CONV, "R10 conversion minimum",
                t_fall - HALF_CYC - 1, T_CONV);
          waiting = 0;
        end
        check(!convst, "R5 convst low while clocking", convst, 0);
        rises++;
      end
      if (busy) bspan++;
      if (vl_prev) check(!valid, "R7 strobe width", valid, 0);
      if (valid) begin
        n_valid++;
        check(!busy, "R7 busy clears with strobe", busy, 0);
        check(bspan == TOTAL, "R8 busy span", bspan, TOTAL);
        check(rises == 8, "R4 pulse count", rises, 8);
        if (exp_q.size() == 0) begin
          check(0, "R9 unexpected result", data, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(data == e, "R6 sample value", data, e);
        end
        bspan = 0;
        rises = 0;
      end
      cv_prev = convst;
      sk_prev = sclk;
      vl_prev = valid;
    end
  end

  logic [7:0] last_res = 0;
  bit         have_last = 0;

  task automatic do_sample(input logic [7:0] code, input int poke);
    while (busy) @(negedge clk);
    if (have_last) check(data == last_res, "R7 data held", data, last_res);
    adc_code = code;
    exp_q.push_back(code);
    n_req++;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke > 0) begin
      repeat (poke - 1) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check(cv_rises == n_req, "R9 no restart", cv_rises, n_req);
    check(n_valid == n_req, "R9 one result per request", n_valid, n_req);
    last_res  = code;
    have_last = 1;
  endtask

  initial begin
    rst_n    = 1'b0;
    start    = 1'b0;
    adc_code = 8'h00;
    repeat (3) @(negedge clk);
    check(!busy && !valid && !convst && !sclk, "R1 reset state",
          {busy, valid, convst, sclk}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !convst && !sclk, "R1 idle without start",
          {busy, convst, sclk}, 0);
    do_sample(8'hA5, 0);                                   // R6 alternating
    do_sample(8'h00, 50);                                  // R9 poke in autozero
    do_sample(8'hFF, 2000);                                // R9 poke in wait
    do_sample(8'h80, 3700);                                // R6 MSB only, R9 readout
    do_sample(8'h01, AZ_CYC + CONV_CYC + 16 * HALF_CYC + 5); // R9 poke in gap
    do_sample(8'h5A, 0);
    do_sample(8'h7F, 0);
    do_sample(8'hC3, 0);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_valid, n_req);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule